// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 style management transactions to Ethernet PHYs. A host raises a one-cycle request that carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces a complete serial frame on the MDC clock output and the MDIO data line, and signals completion with a one-cycle done pulse. Read data and an error flag are held until the next request.

The MDIO pad is modelled as three signals: an output value, an output enable and a separate input sample. MDC is made by dividing the system clock. Each MDC half-period lasts `DIV_HALF` system clocks, and with the default of 10 at a 50 MHz system clock MDC runs at 2.5 MHz. Every frame carries a 33-bit preamble of ones. A read is cut short with an error when the PHY does not pull the line low during the first turnaround bit.

Frame bit slots are numbered from 0. Each slot is one MDC cycle: a low half followed by a high half. Slot 0 starts on the clock edge that accepts the request.

Top module: `mdio_master`

## Requirements
- R1: MDC is low for the first `DIV_HALF` system clocks of each slot and high for the next `DIV_HALF`. It stays low during reset and whenever no frame is active.
- R2: Slots 0 to 32 drive a 1, which gives a 33-bit preamble.
- R3: Slots 33 and 34 drive the start pattern 0 then 1. Slots 35 and 36 carry the opcode: 1,0 for a read (`rd_i`=1) and 0,1 for a write.
- R4: Slots 37 to 41 carry the PHY address MSB first. Slots 42 to 46 carry the register address MSB first.
- R5: A driven bit changes only on the clock edge that starts its slot, and it holds for the whole slot, including the MDC rising edge.
- R6: On a write, slots 47 and 48 drive 1 then 0. Slots 49 to 64 drive the write data MSB first. The output enable stays high through slot 64 and drops when the frame ends.
- R7: On a read, the output enable drops at the start of slot 47 and stays low for the rest of the frame. While the enable is low, `mdio_o` is 0.
- R8: On a read, `mdio_i` is sampled in the last system clock of the high half of slot 47. If the sample is 1, the frame ends at that edge: done pulses, `err_o` rises, MDC is low, the enable is off and `rdata_o` keeps its previous value.
- R9: On a read, `mdio_i` is sampled in the last system clock of the high half of each of slots 49 to 64. The samples are assembled MSB first, and `rdata_o` takes the result on the edge that raises done.
- R10: A request is accepted on a clock edge where `req_i` is 1 and `busy_o` is 0. `busy_o` is high from the accepting edge until the frame ends. Requests seen while busy are ignored.
- R11: `done_o` is high for exactly one system clock, in the cycle in which `busy_o` first reads 0. `err_o` is cleared by the next accepted request. `rdata_o` changes only on a successful read.
- R12: During reset, `busy_o`, `done_o`, `err_o`, `mdc_o`, `mdio_o` and `mdio_oe_o` are 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read turnaround not pulled low |
| rdata_o | output | 16 | Last successful read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input sample |

## Verification
The hardest case to reach is a turnaround failure, because the check depends on the line level in one exact system clock, deep inside a read frame. The bench's PHY model keeps a per-frame flag that holds the line high through slot 47. This produces an aborted read between two good reads, so the test shows both the abort and that `rdata_o` and `err_o` recover afterwards. Requests raised mid-frame with different fields test that they are ignored. A request held high across a done pulse tests the first cycle in which a new frame may be accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned PRE_BITS  = 33;
  localparam int unsigned SLOT_ST   = PRE_BITS;
  localparam int unsigned SLOT_OP   = SLOT_ST + 2;
  localparam int unsigned SLOT_PA   = SLOT_OP + 2;
  localparam int unsigned SLOT_RA   = SLOT_PA + 5;
  localparam int unsigned SLOT_TA   = SLOT_RA + 5;
  localparam int unsigned SLOT_DAT  = SLOT_TA + 2;
  localparam int unsigned SLOT_END  = SLOT_DAT + 16;
  localparam int unsigned SLOT_W    = $clog2(SLOT_END + 1);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic        rd;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wd;
  } mdio_req_t;

  // driven value for slot s (turnaround/data of reads handled by caller)
  function automatic logic frame_bit(slot_t s, mdio_req_t r);
    int unsigned si;
    si = 32'(s);
    if (si < SLOT_ST)       return 1'b1;
    else if (si < SLOT_OP)  return (si == SLOT_ST + 1);
    else if (si < SLOT_PA)  return (si == SLOT_OP) ? r.rd : ~r.rd;
    else if (si < SLOT_RA)  return r.pa[3'(4 - (si - SLOT_PA))];
    else if (si < SLOT_TA)  return r.ra[3'(4 - (si - SLOT_RA))];
    else if (si < SLOT_DAT) return (si == SLOT_TA);
    else if (si < SLOT_END) return r.wd[4'(15 - (si - SLOT_DAT))];
    else                    return 1'b0;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic slot_end_o
);
  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             last;

  assign last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run_i) begin
      if (last) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc_o      = phase_q;
  assign slot_end_o = run_i && last && phase_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  mdio_req_t req_d_i,
  input  logic      slot_end_i,
  input  logic      ta_bad_i,
  output logic      accept_o,
  output logic      active_o,
  output slot_t     slot_o,
  output logic      rd_o,
  output logic      mdio_o,
  output logic      oe_o,
  output logic      done_o
);
  localparam slot_t S_TA   = slot_t'(SLOT_TA);
  localparam slot_t S_LAST = slot_t'(SLOT_END - 1);

  mdio_req_t req_q;
  logic      active_q, mdio_q, oe_q, done_q;
  slot_t     slot_q, slot_nxt;
  logic      finish, released;

  assign accept_o = req_i && !active_q;
  assign slot_nxt = slot_q + 1'b1;
  assign finish   = (slot_q == S_LAST) || ta_bad_i;
  // read frames hand the line to the PHY from the turnaround onward
  assign released = req_q.rd && (slot_nxt >= S_TA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      active_q <= 1'b0;
      slot_q   <= '0;
      mdio_q   <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        req_q    <= req_d_i;
        active_q <= 1'b1;
        slot_q   <= '0;
        mdio_q   <= frame_bit('0, req_d_i);
        oe_q     <= 1'b1;
      end else if (active_q && slot_end_i) begin
        if (finish) begin
          active_q <= 1'b0;
          slot_q   <= '0;
          mdio_q   <= 1'b0;
          oe_q     <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          slot_q <= slot_nxt;
          mdio_q <= released ? 1'b0 : frame_bit(slot_nxt, req_q);
          oe_q   <= ~released;
        end
      end
    end
  end

  assign active_o = active_q;
  assign slot_o   = slot_q;
  assign rd_o     = req_q.rd;
  assign mdio_o   = mdio_q;
  assign oe_o     = oe_q;
  assign done_o   = done_q;

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        accept_i,
  input  logic        active_i,
  input  logic        slot_end_i,
  input  slot_t       slot_i,
  input  logic        rd_i,
  input  logic        mdio_i,
  output logic        ta_bad_o,
  output logic        err_o,
  output logic [15:0] rdata_o
);
  localparam slot_t S_TA   = slot_t'(SLOT_TA);
  localparam slot_t S_DAT  = slot_t'(SLOT_DAT);
  localparam slot_t S_LAST = slot_t'(SLOT_END - 1);

  logic [15:0] shift_q, rdata_q;
  logic        err_q, sample;

  assign ta_bad_o = active_i && rd_i && (slot_i == S_TA) && mdio_i;
  assign sample   = active_i && slot_end_i && rd_i && (slot_i >= S_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept_i) err_q <= 1'b0;
      else if (slot_end_i && ta_bad_o) err_q <= 1'b1;
      if (sample) begin
        shift_q <= {shift_q[14:0], mdio_i};
        if (slot_i == S_LAST) rdata_q <= {shift_q[14:0], mdio_i};
      end
    end
  end

  assign err_o   = err_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_HALF = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  mdio_req_t req_d;
  logic      accept, active, slot_end, ta_bad, rd;
  slot_t     slot;

  assign req_d = '{rd: rd_i, pa: phy_addr_i, ra: reg_addr_i, wd: wdata_i};

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .run_i      (active),
    .mdc_o      (mdc_o),
    .slot_end_o (slot_end)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_d_i    (req_d),
    .slot_end_i (slot_end),
    .ta_bad_i   (ta_bad),
    .accept_o   (accept),
    .active_o   (active),
    .slot_o     (slot),
    .rd_o       (rd),
    .mdio_o     (mdio_o),
    .oe_o       (mdio_oe_o),
    .done_o     (done_o)
  );

  mdio_rx_capture u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .active_i   (active),
    .slot_end_i (slot_end),
    .slot_i     (slot),
    .rd_i       (rd),
    .mdio_i     (mdio_i),
    .ta_bad_o   (ta_bad),
    .err_o      (err_o),
    .rdata_o    (rdata_o)
  );

  assign busy_o = active;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o); // R1
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o)); // R5
  AST_IDLE_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R9
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R11
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rdata_o   (rdata_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int DIV      = 10;
  localparam int SLOT_CYC = 2 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req = 0, rd = 0, mdio_i = 1;
  logic [4:0]  pa = 0, ra = 0;
  logic [15:0] wd = 0;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;

  mdio_master #(.DIV_HALF(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd),
    .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy, m_rd, m_done, m_err;
  int          k;
  logic [4:0]  m_pa, m_ra;
  logic [15:0] m_wd, m_rdata;
  bit          cap_q[$];
  logic [15:0] phy_data = 16'h0;
  bit          ta_bad = 0;

  function automatic bit exp_bit(int s);
    logic [64:0] fr;
    fr = {33'h1_FFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_pa, m_ra, 2'b10, m_wd};
    return fr[64 - s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_rdata = 0; k = 0; m_rd = 0;
      m_pa = 0; m_ra = 0; m_wd = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req) begin
          m_busy = 1; k = 0; m_err = 0;
          m_rd = rd; m_pa = pa; m_ra = ra; m_wd = wd;
          cap_q.delete();
        end
      end else begin
        if (k % SLOT_CYC == SLOT_CYC - 1) begin
          int s;
          s = k / SLOT_CYC;
          if (m_rd && s == 47 && mdio_i) begin
            m_busy = 0; m_done = 1; m_err = 1;
          end else begin
            if (m_rd && s >= 49) cap_q.push_back(mdio_i);
            if (s == 64) begin
              m_busy = 0; m_done = 1;
              if (m_rd) begin
                m_rdata = 0;
                foreach (cap_q[i]) m_rdata = {m_rdata[14:0], cap_q[i]};
              end
            end
          end
        end
        k++;
      end
    end
  end

  task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int  s;
    bit  oe_e, mdo_e, mdc_e;
    string t;
    s     = k / SLOT_CYC;
    mdc_e = m_busy ? ((k / DIV) % 2) : 0;
    oe_e  = m_busy && !(m_rd && s >= 47);
    mdo_e = oe_e ? exp_bit(s) : 0;
    if (!rst_n) begin
      chk("R12", "busy", 16'(busy), 0);
      chk("R12", "done", 16'(done), 0);
      chk("R12", "err", 16'(err), 0);
      chk("R12", "mdc", 16'(mdc), 0);
      chk("R12", "mdio_o", 16'(mdio_o), 0);
      chk("R12", "oe", 16'(mdio_oe), 0);
      chk("R12", "rdata", rdata, 0);
    end else begin
      chk("R1", "mdc", 16'(mdc), 16'(mdc_e));
      if (!m_busy || s < 33) t = "R2 R5";
      else if (s < 37) t = "R3 R5";
      else if (s < 47) t = "R4 R5";
      else if (m_rd) t = "R7";
      else t = "R6 R5";
      chk(t, "mdio_o", 16'(mdio_o), 16'(mdo_e));
      chk(m_rd ? "R7" : "R6", "oe", 16'(mdio_oe), 16'(oe_e));
      chk("R10", "busy", 16'(busy), 16'(m_busy));
      chk("R11", "done", 16'(done), 16'(m_done));
      chk("R8", "err", 16'(err), 16'(m_err));
      chk("R9", "rdata", rdata, m_rdata);
    end
    // PHY model
    if (oe_e) mdio_i <= mdo_e;
    else if (m_busy && s == 47) mdio_i <= ta_bad;
    else if (m_busy && s == 48) mdio_i <= 1'b0;
    else if (m_busy && s >= 49 && s <= 64) mdio_i <= phy_data[15 - (s - 49)];
    else mdio_i <= 1'b1;
  end

  task automatic issue(bit r, logic [4:0] a, logic [4:0] g, logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; rd = r; pa = a; ra = g; wd = d;
    @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);                    // R12 checked while low
    rst_n = 1;
    repeat (4) @(negedge clk);
    issue(0, 5'h13, 5'h0A, 16'hA5C3);             // R2 R3 R4 R6 write
    phy_data = 16'h1234; ta_bad = 0;
    issue(1, 5'h01, 5'h02, 16'h0);                // R7 R9 read
    ta_bad = 1; phy_data = 16'hFFFF;
    issue(1, 5'h1F, 5'h1F, 16'h0);                // R8 abort, rdata kept
    ta_bad = 0; phy_data = 16'hBEEF;
    issue(1, 5'h00, 5'h03, 16'h0);                // R8 err cleared, R9
    issue(0, 5'h00, 5'h1F, 16'h0000);
    issue(0, 5'h1F, 5'h00, 16'hFFFF);
    // R10: request changes mid-frame are ignored
    @(negedge clk);
    req = 1; rd = 0; pa = 5'h0C; ra = 5'h05; wd = 16'h8001;
    @(negedge clk);
    req = 0;
    repeat (300) @(negedge clk);
    req = 1; rd = 1; pa = 5'h1E; ra = 5'h11; wd = 16'h7777;
    repeat (60) @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
    // R10 R11: request held across done is taken the next cycle
    phy_data = 16'h5A0F;
    @(negedge clk);
    req = 1; rd = 1; pa = 5'h07; ra = 5'h04;
    while (!done) @(negedge clk);
    @(negedge clk);
    while (!busy) @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule